// File: doc/BRIEF.md
# Free-Running 40-bit Time Base

This block keeps a 40-bit count that moves forward by one on every cycle where the tick-enable input is high and counting is switched on. It is the system time base. A slower prescaled strobe of about 983 kHz drives the tick-enable. The count never reloads and raises no interrupt. Software reaches it through a small register bus. One word returns the lower 32 count bits. A second word returns the upper 8 count bits, with the counting switch in bit 8. Software can turn the counting switch on and off by writing that second word.

A 40-bit value cannot be read in one 32-bit access, and a carry may reach the upper bits between the two reads. To prevent a torn value, every low-word read also copies the upper 8 count bits into a shadow register. The next high-word read returns that copy, so a low-then-high pair always forms one sample.

Two small state machines hold the control. The run machine has the states `CNT_HALT` and `CNT_RUN`:
- `CNT_HALT` goes to `CNT_RUN` on a high-word write with bit 8 set.
- `CNT_RUN` goes to `CNT_HALT` on a high-word write with bit 8 clear.

The read-sequence machine has the states `SEQ_LIVE` and `SEQ_SNAP`:
- `SEQ_LIVE` goes to `SEQ_SNAP` on a low-word read.
- `SEQ_SNAP` stays in `SEQ_SNAP` on a further low-word read, which refreshes the shadow.
- `SEQ_SNAP` goes back to `SEQ_LIVE` on a high-word read.

Top module: `tbase40_top`

## Requirements
- R1: Reset clears these:
  - The count goes to the `RST_COUNT` parameter, which defaults to zero.
  - The run machine goes to `CNT_HALT`.
  - The read-sequence machine goes to `SEQ_LIVE`.
  - `bus_rdata` goes to 0.
- R2: While running, the count grows by exactly one in each cycle where `tick_en` is 1. In a cycle where `tick_en` is 0, the count does not change.
- R3: While halted, the count holds its value whatever `tick_en` does.
- R4: A write (`bus_sel`=1, `bus_wr`=1) to offset 0x64 sets the run machine from `bus_wdata` bit 8: 1 runs, 0 halts. All other bits of that write are ignored, and the count is not changed.
- R5: A read (`bus_sel`=1, `bus_wr`=0) is answered on `bus_rdata` one cycle later, and the value is held until the next read. A read of offset 0x60 returns count bits 31:0 as they were in the request cycle.
- R6: A read of offset 0x64 returns:
  - the upper count byte in bits 7:0;
  - the run state in bit 8;
  - zeros in bits 31:9.
- R7: A read of offset 0x60 copies count bits 39:32 into the shadow. The next read of 0x64 returns the shadow, not the live upper byte. A read of 0x64 that follows no such capture returns the live upper byte.
- R8: Counting on from all ones (0xFF_FFFF_FFFF) gives zero.
- R9: Writes to 0x60 or to any other offset change nothing. Reads of any offset other than 0x60 and 0x64 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled count strobe, one increment per high cycle |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, held until the next read |

## Verification
The in-RTL assertions check these on every cycle:
- the increment and hold rules of the count, including its wrap;
- that the run state follows only high-word writes;
- that the shadow is captured on each low-word read;
- that the reserved high bits and unmapped reads return zero;
- that `bus_rdata` holds between reads.

Some behaviour only the bench's scenarios can show:
- that a carry reaching the upper byte between the two reads of a pair is hidden by the shadow;
- that a halted counter, an ignored low-word write and an ignored count-field write leave the readable count where the bench expects it;
- that reset mid-run returns everything to its starting state.

// File: rtl/tbase40_pkg.sv
package tbase40_pkg;

    typedef enum logic {
        CNT_HALT = 1'b0,
        CNT_RUN  = 1'b1
    } run_state_t;

    typedef enum logic {
        SEQ_LIVE = 1'b0,
        SEQ_SNAP = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic rd_lo;
        logic rd_hi;
        logic rd_other;
        logic wr_hi;
    } bus_op_t;

endpackage

// File: rtl/tbase40_bus_decode.sv
module tbase40_bus_decode
    import tbase40_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] LO_OFS = 8'h60,
    parameter logic [ADDR_W-1:0] HI_OFS = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output bus_op_t           op
);

    logic hit_lo;
    logic hit_hi;

    always_comb begin
        hit_lo      = (addr == LO_OFS);
        hit_hi      = (addr == HI_OFS);
        op.rd_lo    = sel && !wr && hit_lo;
        op.rd_hi    = sel && !wr && hit_hi;
        op.rd_other = sel && !wr && !hit_lo && !hit_hi;
        op.wr_hi    = sel && wr && hit_hi;
    end

    // R9: at most one decoded strobe per cycle
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op.rd_lo, op.rd_hi, op.rd_other, op.wr_hi}));

    // R9: a write never decodes as any read
    assert_write_not_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr) |-> !(op.rd_lo || op.rd_hi || op.rd_other));

endmodule

// File: rtl/tbase40_run_ctrl.sv
module tbase40_run_ctrl
    import tbase40_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hi,
    input  logic wr_bit,
    output logic run
);

    run_state_t state_q;
    run_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALT: if (wr_hi && wr_bit)  state_d = CNT_RUN;
            CNT_RUN:  if (wr_hi && !wr_bit) state_d = CNT_HALT;
            default:  state_d = CNT_HALT;
        endcase
    end

    always_comb begin
        run = (state_q == CNT_RUN);
    end

    // R4: a high-word write sets the run state from the written enable bit
    assert_enable_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (run == $past(wr_bit)));

    // R4: without a high-word write the run state does not move
    assert_run_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi |=> $stable(run));

endmodule

// File: rtl/tbase40_count_core.sv
module tbase40_count_core #(
    parameter int               CNT_W     = 40,
    parameter int               SEG_W     = 8,
    parameter logic [CNT_W-1:0] RST_COUNT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    localparam int NSEG = CNT_W / SEG_W;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic             step;

    always_comb begin
        step = run && tick;
    end

    // segmented increment: each segment adds the carry that ripples from below
    always_comb begin
        logic carry;
        carry   = step;
        count_d = count_q;
        for (int g = 0; g < NSEG; g++) begin
            count_d[g*SEG_W +: SEG_W] = count_q[g*SEG_W +: SEG_W] + {{(SEG_W-1){1'b0}}, carry};
            carry = carry && (&count_q[g*SEG_W +: SEG_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= RST_COUNT;
        else        count_q <= count_d;
    end

    always_comb begin
        count = count_q;
    end

    // R2 / R8: one step per enabled tick, wrapping modulo 2**CNT_W
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R2: no tick, no change
    assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_q));

    // R3: halted counter holds
    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count_q));

    // R8: all ones steps to zero
    assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && (&count_q)) |=> (count_q == '0));

endmodule

// File: rtl/tbase40_read_seq.sv
module tbase40_read_seq
    import tbase40_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 8,
    parameter int EN_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_t           op,
    input  logic [DATA_W-1:0] count_lo,
    input  logic [HI_W-1:0]   count_hi,
    input  logic              run,
    output logic [DATA_W-1:0] rdata
);

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic [HI_W-1:0]   shadow_q;
    logic [HI_W-1:0]   hi_sel;
    logic [DATA_W-1:0] hi_word;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_LIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_LIVE: if (op.rd_lo) state_d = SEQ_SNAP;
            SEQ_SNAP: if (op.rd_hi) state_d = SEQ_LIVE;
            default:  state_d = SEQ_LIVE;
        endcase
    end

    always_comb begin
        hi_sel          = (state_q == SEQ_SNAP) ? shadow_q : count_hi;
        hi_word         = '0;
        hi_word[HI_W-1:0] = hi_sel;
        hi_word[EN_BIT] = run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            shadow_q <= '0;
        end else if (op.rd_lo) begin
            rdata_q  <= count_lo;
            shadow_q <= count_hi;
        end else if (op.rd_hi) begin
            rdata_q  <= hi_word;
        end else if (op.rd_other) begin
            rdata_q  <= '0;
        end
    end

    always_comb begin
        rdata = rdata_q;
    end

    // R7: a low-word read arms the snapshot with the upper byte of that cycle
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op.rd_lo |=> ((state_q == SEQ_SNAP) && (shadow_q == $past(count_hi))));

    // R7: the high read after a capture returns the shadow and disarms
    assert_snap_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op.rd_hi && (state_q == SEQ_SNAP)) |=>
            ((rdata_q[HI_W-1:0] == $past(shadow_q)) && (state_q == SEQ_LIVE)));

    // R6: reserved high-word bits read as zero
    assert_hi_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op.rd_hi |=> (rdata_q[DATA_W-1:EN_BIT+1] == '0));

    // R9: unmapped reads return zero
    assert_other_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op.rd_other |=> (rdata_q == '0));

    // R5: read data holds until the next read
    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(op.rd_lo || op.rd_hi || op.rd_other) |=> $stable(rdata_q));

endmodule

// File: rtl/tbase40_top.sv
module tbase40_top
    import tbase40_pkg::*;
#(
    parameter int                 CNT_W     = 40,
    parameter int                 DATA_W    = 32,
    parameter int                 ADDR_W    = 8,
    parameter int                 SEG_W     = 8,
    parameter int                 EN_BIT    = 8,
    parameter logic [ADDR_W-1:0]  LO_OFS    = 8'h60,
    parameter logic [ADDR_W-1:0]  HI_OFS    = 8'h64,
    parameter logic [CNT_W-1:0]   RST_COUNT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int HI_W = CNT_W - DATA_W;

    bus_op_t          op;
    logic             run;
    logic [CNT_W-1:0] count;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata;

    tbase40_bus_decode #(
        .ADDR_W (ADDR_W),
        .LO_OFS (LO_OFS),
        .HI_OFS (HI_OFS)
    ) decode_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .op    (op)
    );

    tbase40_run_ctrl run_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hi  (op.wr_hi),
        .wr_bit (bus_wdata[EN_BIT]),
        .run    (run)
    );

    tbase40_count_core #(
        .CNT_W     (CNT_W),
        .SEG_W     (SEG_W),
        .RST_COUNT (RST_COUNT)
    ) core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick_en),
        .count (count)
    );

    tbase40_read_seq #(
        .DATA_W (DATA_W),
        .HI_W   (HI_W),
        .EN_BIT (EN_BIT)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .count_lo (count[DATA_W-1:0]),
        .count_hi (count[CNT_W-1:DATA_W]),
        .run      (run),
        .rdata    (bus_rdata)
    );

    // R4: a high-word write never changes the count in the same step beyond one tick
    assert_write_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op.wr_hi && !tick_en) |=> $stable(count));

endmodule

// File: tb/tbase40_top_tb_top.sv
`timescale 1ns/1ps
module tbase40_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_a = 1'b0;
    logic        tick_b = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a;
    logic [31:0] rdata_b;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    tbase40_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_a), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a)
    );

    // second instance starts just below all ones to reach the wrap quickly
    tbase40_top #(.RST_COUNT(40'hFF_FFFF_FFFE)) dut_wrap_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_b), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b)
    );

    // entry: op[77:76] (0 read, 1 write, 2 tick), addr[75:68], data[67:36], expect[35:4], req[3:0]
    localparam int NV = 26;
    localparam logic [77:0] VEC [0:NV-1] = '{
        {2'd0, 8'h60, 32'h0,        32'h0,   4'd1},  // R1 low after reset
        {2'd0, 8'h64, 32'h0,        32'h0,   4'd1},  // R1 high after reset
        {2'd2, 8'h00, 32'd5,        32'h0,   4'd3},  // R3 ticks while halted
        {2'd0, 8'h60, 32'h0,        32'h0,   4'd3},  // R3
        {2'd1, 8'h64, 32'h100,      32'h0,   4'd4},  // R4 start
        {2'd0, 8'h64, 32'h0,        32'h100, 4'd4},  // R4
        {2'd2, 8'h00, 32'd7,        32'h0,   4'd2},  // R2
        {2'd0, 8'h60, 32'h0,        32'd7,   4'd5},  // R5
        {2'd0, 8'h64, 32'h0,        32'h100, 4'd6},  // R6
        {2'd1, 8'h60, 32'hDEADBEEF, 32'h0,   4'd9},  // R9 write low ignored
        {2'd0, 8'h60, 32'h0,        32'd7,   4'd9},  // R9
        {2'd1, 8'h64, 32'h1FF,      32'h0,   4'd4},  // R4 count field ignored
        {2'd0, 8'h64, 32'h0,        32'h100, 4'd4},  // R4
        {2'd0, 8'h60, 32'h0,        32'd7,   4'd4},  // R4
        {2'd2, 8'h00, 32'd3,        32'h0,   4'd2},  // R2
        {2'd0, 8'h60, 32'h0,        32'd10,  4'd2},  // R2
        {2'd1, 8'h64, 32'h0,        32'h0,   4'd4},  // R4 halt
        {2'd2, 8'h00, 32'd4,        32'h0,   4'd3},  // R3
        {2'd0, 8'h60, 32'h0,        32'd10,  4'd3},  // R3
        {2'd0, 8'h64, 32'h0,        32'h0,   4'd3},  // R3
        {2'd1, 8'h10, 32'hFFFFFFFF, 32'h0,   4'd9},  // R9 unmapped write
        {2'd0, 8'h64, 32'h0,        32'h0,   4'd9},  // R9 still halted
        {2'd1, 8'h64, 32'hFFFFFFFF, 32'h0,   4'd6},  // R6 all ones written
        {2'd0, 8'h64, 32'h0,        32'h100, 4'd6},  // R6 reserved bits zero
        {2'd0, 8'h00, 32'h0,        32'h0,   4'd9},  // R9 unmapped read
        {2'd0, 8'h68, 32'h0,        32'h0,   4'd9}   // R9
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic ticks(input int n, input bit wrap_side);
        @(negedge clk);
        if (wrap_side) tick_b = 1'b1; else tick_a = 1'b1;
        repeat (n) @(negedge clk);
        tick_a = 1'b0; tick_b = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(rdata_a, 32'h0, "R1", "rdata at reset");

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [7:0]  ad;
            logic [31:0] dt;
            logic [31:0] ex;
            logic [3:0]  rq;
            {op, ad, dt, ex, rq} = VEC[i];
            if (op == 2'd0) begin
                bus_op(1'b0, ad, 32'h0);
                check(rdata_a, ex, $sformatf("R%0d", rq), $sformatf("vector %0d", i));
            end else if (op == 2'd1) begin
                bus_op(1'b1, ad, dt);
            end else begin
                ticks(int'(dt), 1'b0);
            end
        end

        // R5: read data holds across idle cycles and ticks
        bus_op(1'b0, 8'h60, 32'h0);
        ticks(3, 1'b0);
        check(rdata_a, 32'd10, "R5", "low read value");
        bus_op(1'b0, 8'h60, 32'h0);
        check(rdata_a, 32'd13, "R5", "fresh low read");
        ticks(2, 1'b0);
        repeat (3) @(negedge clk);
        check(rdata_a, 32'd13, "R5", "rdata held between reads");

        // R1: reset in the middle of a run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check(rdata_a, 32'h0, "R1", "rdata after reset");
        bus_op(1'b0, 8'h64, 32'h0);
        check(rdata_a, 32'h0, "R1", "halted with zero upper byte");
        ticks(4, 1'b0);
        bus_op(1'b0, 8'h60, 32'h0);
        check(rdata_a, 32'h0, "R1", "count zero and halted after reset");

        // R7 and R8 on the instance reset just below all ones
        bus_op(1'b0, 8'h60, 32'h0);
        check(rdata_b, 32'hFFFF_FFFE, "R8", "preset low word");
        bus_op(1'b1, 8'h64, 32'h100);
        bus_op(1'b0, 8'h60, 32'h0);
        check(rdata_b, 32'hFFFF_FFFE, "R7", "low of pair");
        ticks(3, 1'b1);
        bus_op(1'b0, 8'h64, 32'h0);
        check(rdata_b, 32'h1FF, "R7", "high of pair from shadow");
        bus_op(1'b0, 8'h64, 32'h0);
        check(rdata_b, 32'h100, "R8", "live upper byte wrapped to zero");
        bus_op(1'b0, 8'h60, 32'h0);
        check(rdata_b, 32'h1, "R8", "low word after wrap");
        ticks(1, 1'b1);
        bus_op(1'b0, 8'h60, 32'h0);
        check(rdata_b, 32'h2, "R7", "second low read refreshes");
        bus_op(1'b0, 8'h64, 32'h0);
        check(rdata_b, 32'h100, "R7", "high after refresh");

        finish_run();
    end

endmodule